// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns three synchronous comparator flags into one ordered set of supervisor outputs. The flags report that the monitor pin is below its threshold, that the supply is below its trip point, and that the supply is below the battery. The outputs are:

- an active-low early-warning interrupt;
- a pair of complementary reset outputs;
- a write-protect request for the memory chip-enable gate;
- a power-fail output for the external supply switch.

On the way down, the interrupt comes first. Reset and write protection follow at the trip point, and power-fail follows at the battery crossover. On the way up, power-fail clears as soon as the supply is above the battery. Reset is then held for a fixed number of cycles after the supply passes its trip point.

While the block is running normally, a watchdog expects a rising edge on the strobe input within a fixed window. If no edge arrives, the block issues a reset of the same length as the power-up reset. A supply failure always takes over from a watchdog reset. The block leaves its own reset in the power-up hold state, so a power-on reset is issued without any further stimulus.

The sequencer has five states:

| State | Meaning |
|---|---|
| `SEQ_RUN` | Normal operation |
| `SEQ_SUPPLY_LOW` | Supply below its trip point |
| `SEQ_ON_BATTERY` | Supply below the battery |
| `SEQ_PWRUP_HOLD` | Reset held after power returns |
| `SEQ_WDOG_HOLD` | Watchdog reset |

Its transitions are:

- From any state, the battery flag moves to `SEQ_ON_BATTERY`.
- From any state other than `SEQ_ON_BATTERY`, the trip flag without the battery flag moves to `SEQ_SUPPLY_LOW`.
- `SEQ_ON_BATTERY` with only the trip flag set returns to `SEQ_SUPPLY_LOW`.
- `SEQ_ON_BATTERY` or `SEQ_SUPPLY_LOW` with both flags clear moves to `SEQ_PWRUP_HOLD`.
- `SEQ_PWRUP_HOLD` or `SEQ_WDOG_HOLD` returns to `SEQ_RUN` when the hold timer ends.
- `SEQ_RUN` moves to `SEQ_WDOG_HOLD` when the watchdog expires.

Top module: `pwr_fail_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `rst_hi`=1, `rst_lo_n`=0, `wprot`=1, `pfail`=0 and `nmi_n`=1.
- R2: `nmi_n` equals the inverse of `mon_low` as sampled at the previous rising edge, in every state. A later drop of `mon_low` produces a new interrupt.
- R3: After an edge that samples `vcc_trip`=1, `rst_hi`=1, `rst_lo_n`=0 and `wprot`=1.
- R4: After an edge that samples `vcc_below_bat`=1, `pfail`=1, and reset and write protection are also active, even if `vcc_trip` is 0.
- R5: After an edge that samples `vcc_below_bat`=0, `pfail`=0. While `vcc_trip` stays 1, reset stays active.
- R6: Once `vcc_trip` and `vcc_below_bat` are both seen clear, reset and `wprot` stay active until the (HOLD_CYCLES+1)-th rising edge. If the trip flag returns during the hold, the count restarts. After `rst_n` is released, reset falls on the HOLD_CYCLES-th edge.
- R7: In normal operation without strobe edges, reset rises on the WDOG_CYCLES-th edge after the edge on which reset fell. During the watchdog reset, `wprot` stays 0.
- R8: A watchdog reset lasts HOLD_CYCLES edges.
- R9: Only a rising edge of `wdog_strobe` restarts the watchdog. The restart happens on the edge that samples the strobe high after it was low, and reset then rises on the WDOG_CYCLES-th edge after that one. A strobe edge sampled on the same edge as expiry wins, so strobe edges spaced at most WDOG_CYCLES edges apart never cause a reset. A strobe held high does not restart the watchdog again.
- R10: A trip flag seen during a watchdog reset moves the block into the supply-low state, with `wprot`=1. After that, recovery follows R6.
- R11: `rst_lo_n` is always the complement of `rst_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_low | input | 1 | Monitor pin below its threshold (synchronous) |
| vcc_trip | input | 1 | Supply below its trip point (synchronous) |
| vcc_below_bat | input | 1 | Supply below the battery level (synchronous) |
| wdog_strobe | input | 1 | Watchdog strobe; rising edges restart the watchdog |
| nmi_n | output | 1 | Active-low early-warning interrupt |
| rst_hi | output | 1 | Active-high reset |
| rst_lo_n | output | 1 | Active-low reset |
| wprot | output | 1 | Write-protect request to the chip-enable gate |
| pfail | output | 1 | Power-fail output, battery crossover |

## Verification
The checker verifies the following on every cycle:

- the two reset outputs are complementary;
- the interrupt tracks the monitor flag with one cycle of latency;
- a trip flag always produces reset and write protection on the next cycle;
- `pfail` follows the battery flag on the next cycle;
- `pfail` implies write protection, and write protection implies reset.

Only the bench scenarios can show the durations: the power-up hold, the restart of the hold after a brief dip, the watchdog window and the watchdog reset length. The bench also sweeps the strobe spacing across the expiry boundary, including the case where a strobe edge coincides with expiry, and covers the held-high strobe.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [2:0] {
        SEQ_RUN,
        SEQ_SUPPLY_LOW,
        SEQ_ON_BATTERY,
        SEQ_PWRUP_HOLD,
        SEQ_WDOG_HOLD
    } seq_state_e;
endpackage

// File: rtl/pfs_cycle_timer.sv
// Up-counter that saturates at LIMIT-1. A synchronous clear returns it to zero.
module pfs_cycle_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfs_strobe_edge.sv
// Detects a rising edge on the watchdog strobe input.
module pfs_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic prev;

    assign rise = strobe & ~prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= strobe;
        end
    end
endmodule

// File: rtl/pfs_seq_fsm.sv
// Ordering state machine: one process holds the state register,
// one computes the next state, and one decodes the outputs.
module pfs_seq_fsm
    import pfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_trip,
    input  logic vcc_below_bat,
    input  logic hold_done,
    input  logic wdog_expire,
    output logic in_run,
    output logic in_hold,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic wprot,
    output logic pfail
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_PWRUP_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_RUN: begin
                if (vcc_below_bat)    state_nx = SEQ_ON_BATTERY;
                else if (vcc_trip)    state_nx = SEQ_SUPPLY_LOW;
                else if (wdog_expire) state_nx = SEQ_WDOG_HOLD;
            end
            SEQ_SUPPLY_LOW: begin
                if (vcc_below_bat)    state_nx = SEQ_ON_BATTERY;
                else if (!vcc_trip)   state_nx = SEQ_PWRUP_HOLD;
            end
            SEQ_ON_BATTERY: begin
                if (!vcc_below_bat) begin
                    state_nx = vcc_trip ? SEQ_SUPPLY_LOW : SEQ_PWRUP_HOLD;
                end
            end
            SEQ_PWRUP_HOLD, SEQ_WDOG_HOLD: begin
                if (vcc_below_bat)    state_nx = SEQ_ON_BATTERY;
                else if (vcc_trip)    state_nx = SEQ_SUPPLY_LOW;
                else if (hold_done)   state_nx = SEQ_RUN;
            end
            default:                  state_nx = SEQ_PWRUP_HOLD;
        endcase
    end

    always_comb begin
        in_run   = 1'b0;
        in_hold  = 1'b0;
        rst_hi   = 1'b1;
        rst_lo_n = 1'b0;
        wprot    = 1'b1;
        pfail    = 1'b0;
        unique case (state)
            SEQ_RUN: begin
                in_run   = 1'b1;
                rst_hi   = 1'b0;
                rst_lo_n = 1'b1;
                wprot    = 1'b0;
            end
            SEQ_SUPPLY_LOW: begin
            end
            SEQ_ON_BATTERY: begin
                pfail    = 1'b1;
            end
            SEQ_PWRUP_HOLD: begin
                in_hold  = 1'b1;
            end
            SEQ_WDOG_HOLD: begin
                in_hold  = 1'b1;
                wprot    = 1'b0;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq #(
    parameter int HOLD_CYCLES = 2000,
    parameter int WDOG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_low,
    input  logic vcc_trip,
    input  logic vcc_below_bat,
    input  logic wdog_strobe,
    output logic nmi_n,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic wprot,
    output logic pfail
);
    logic in_run, in_hold, hold_done, wd_done, strobe_rise, wdog_expire;

    pfs_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (wdog_strobe),
        .rise   (strobe_rise)
    );

    pfs_cycle_timer #(.LIMIT(HOLD_CYCLES)) u_hold_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~in_hold),
        .done  (hold_done)
    );

    pfs_cycle_timer #(.LIMIT(WDOG_CYCLES)) u_wdog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (strobe_rise | ~in_run),
        .done  (wd_done)
    );

    // A strobe edge on the expiry cycle keeps the block running.
    assign wdog_expire = wd_done & ~strobe_rise;

    pfs_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_trip      (vcc_trip),
        .vcc_below_bat (vcc_below_bat),
        .hold_done     (hold_done),
        .wdog_expire   (wdog_expire),
        .in_run        (in_run),
        .in_hold       (in_hold),
        .rst_hi        (rst_hi),
        .rst_lo_n      (rst_lo_n),
        .wprot         (wprot),
        .pfail         (pfail)
    );

    // Early-warning interrupt: registered copy of the monitor flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_n <= 1'b1;
        end else begin
            nmi_n <= ~mon_low;
        end
    end
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker (
    input logic clk,
    input logic rst_n,
    input logic mon_low,
    input logic vcc_trip,
    input logic vcc_below_bat,
    input logic nmi_n,
    input logic rst_hi,
    input logic rst_lo_n,
    input logic wprot,
    input logic pfail
);
    AST_RST_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lo_n == !rst_hi); // R11
    AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mon_low |=> !nmi_n); // R2
    AST_NMI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_low |=> nmi_n); // R2
    AST_TRIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_trip |=> (rst_hi && wprot)); // R3
    AST_BAT_PFAIL: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_bat |=> pfail); // R4
    AST_PFAIL_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        pfail |-> (wprot && rst_hi)); // R4
    AST_PFAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_below_bat |=> !pfail); // R5
    AST_WPROT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        wprot |-> rst_hi); // R6
endmodule

bind pwr_fail_seq pfs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mon_low       (mon_low),
    .vcc_trip      (vcc_trip),
    .vcc_below_bat (vcc_below_bat),
    .nmi_n         (nmi_n),
    .rst_hi        (rst_hi),
    .rst_lo_n      (rst_lo_n),
    .wprot         (wprot),
    .pfail         (pfail)
);

// File: tb/tb_pwr_fail_seq.sv
`timescale 1ns/1ps
module tb_pwr_fail_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 8;
    localparam int WD   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_low = 1'b0, vcc_trip = 1'b0, vcc_below_bat = 1'b0, wdog_strobe = 1'b0;
    logic nmi_n, rst_hi, rst_lo_n, wprot, pfail;
    int n_total = 0;
    int n_fail  = 0;
    int k;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_fail_seq #(.HOLD_CYCLES(HOLD), .WDOG_CYCLES(WD)) dut (
        .clk(clk), .rst_n(rst_n), .mon_low(mon_low), .vcc_trip(vcc_trip),
        .vcc_below_bat(vcc_below_bat), .wdog_strobe(wdog_strobe),
        .nmi_n(nmi_n), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n),
        .wprot(wprot), .pfail(pfail)
    );

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n_total++;
        if (rst_lo_n == rst_hi) begin
            n_fail++;
            $display("FAIL R11: actual rst_lo_n %0d expected %0d", rst_lo_n, !rst_hi);
        end
        n_total--;
    endtask

    // Counts rising edges until rst_hi takes the wanted value.
    task automatic edges_until(input logic want, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (rst_hi != want && n < 10 * (WD + HOLD));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rst_hi", rst_hi, 1);
        check("R1 rst_lo_n", rst_lo_n, 0);
        check("R1 wprot", wprot, 1);
        check("R1 pfail", pfail, 0);
        check("R1 nmi_n", nmi_n, 1);

        // R6: power-on hold after reset release
        rst_n = 1'b1;
        edges_until(1'b0, k);
        check("R6 power-on hold edges", k, HOLD);
        check("R6 wprot after hold", wprot, 0);

        // R2: interrupt tracks monitor, twice
        for (int i = 0; i < 2; i++) begin
            mon_low = 1'b1;
            step();
            check("R2 nmi asserted", nmi_n, 0);
            check("R2 no reset from monitor", rst_hi, 0);
            mon_low = 1'b0;
            step();
            check("R2 nmi released", nmi_n, 1);
        end

        // R3/R4/R5/R6: power-down and power-up sequence
        mon_low = 1'b1;
        step();
        check("R2 early warning", nmi_n, 0);
        check("R3 reset before trip", rst_hi, 0);
        vcc_trip = 1'b1;
        step();
        check("R3 rst_hi", rst_hi, 1);
        check("R3 rst_lo_n", rst_lo_n, 0);
        check("R3 wprot", wprot, 1);
        check("R3 pfail still low", pfail, 0);
        vcc_below_bat = 1'b1;
        step();
        check("R4 pfail", pfail, 1);
        check("R4 wprot", wprot, 1);
        vcc_below_bat = 1'b0;
        step();
        check("R5 pfail cleared", pfail, 0);
        check("R5 reset held", rst_hi, 1);
        vcc_trip = 1'b0;
        mon_low = 1'b0;
        edges_until(1'b0, k);
        check("R6 power-up hold edges", k, HOLD + 1);

        // R7/R8: watchdog expiry with no strobes
        edges_until(1'b1, k);
        check("R7 watchdog window", k, WD);
        check("R7 wprot in watchdog reset", wprot, 0);
        edges_until(1'b0, k);
        check("R8 watchdog reset length", k, HOLD);

        // R9: sweep of strobe spacing across the expiry boundary
        for (int t = 2; t <= WD + 1; t++) begin
            wdog_strobe = 1'b1;
            step();
            wdog_strobe = 1'b0;
            repeat (t - 1) step();
            check($sformatf("R9 spacing %0d", t), rst_hi, (t - 1 >= WD) ? 1 : 0);
        end
        edges_until(1'b0, k);
        check("R8 watchdog reset after sweep", k, HOLD);

        // R9: held-high strobe restarts only once
        wdog_strobe = 1'b1;
        edges_until(1'b1, k);
        check("R9 held strobe expiry", k, WD + 1);
        wdog_strobe = 1'b0;

        // R10: trip flag during watchdog reset
        vcc_trip = 1'b1;
        step();
        check("R10 wprot on trip", wprot, 1);
        check("R10 reset on trip", rst_hi, 1);
        vcc_trip = 1'b0;
        edges_until(1'b0, k);
        check("R10 recovery hold", k, HOLD + 1);

        // R4: battery flag alone, from normal operation
        vcc_below_bat = 1'b1;
        step();
        check("R4 pfail without trip", pfail, 1);
        check("R4 reset without trip", rst_hi, 1);
        vcc_below_bat = 1'b0;
        step();
        check("R5 pfail clear from battery", pfail, 0);
        check("R6 wprot in hold", wprot, 1);

        // R6: trip returns during the hold, count restarts
        repeat (HOLD / 2) step();
        vcc_trip = 1'b1;
        step();
        vcc_trip = 1'b0;
        edges_until(1'b0, k);
        check("R6 restarted hold", k, HOLD + 1);

        finish_run();
    end
endmodule